// File: doc/BRIEF.md
# SPI EEPROM page-write sequencer

This block writes a run of 16-bit words into a serial EEPROM over a four-wire SPI link. A caller gives a start word offset and a word count and pulses `start`. The words then arrive on a valid/ready stream. The sequencer first checks that the run fits inside the device. It then works through the run one page burst at a time.

For each burst, the block:

1. Asks for bus ownership and waits for a grant.
2. Selects the part and polls its status register until the part is idle.
3. Sends a write-enable command in its own chip-select frame.
4. Sends the write command, the byte address and as many byte-swapped data words as fit before the next page boundary.
5. Waits out the internal program time and releases the bus.

If words remain after a burst, a new burst starts with a fresh request.

Completion is signalled by a one-cycle `done` pulse. The `err` flag is raised with `done` when the request was out of range, the grant never came, or the part stayed busy. `err` holds until the next `start`. Every width, delay and retry limit is a parameter. The defaults describe a 256-word part with 8 address bits and 32-byte pages.

Top module: `spi_eeprom_page_writer`

## Requirements
- R1: A request is rejected when the start offset is not less than WORD_SIZE, when the count exceeds WORD_SIZE minus the offset, or when the count is zero. On a rejected request `done` and `err` rise together one cycle after `start`, `access_req` never rises and no chip-select frame occurs.
- R2: `access_req` rises before any serial activity. `csn` stays high and `sk` stays low while the grant is absent, and `sk` only toggles while `csn` is low.
- R3: If `access_gnt` is still low after GNT_TRIES polls spaced POLL_DLY cycles apart, `access_req` drops and the block finishes with `err` set, without having selected the part.
- R4: Readiness is tested with a frame made of the 8-bit read-status opcode 0x05 followed by 8 status bits clocked in MSB first. Only bit 0 (1 = busy) is examined, and a busy answer is followed by a chip-select high pulse and another poll.
- R5: After RDY_TRIES busy answers in a row, the block releases the bus and finishes with `err` set, having sent no write. Exactly RDY_TRIES status frames are sent.
- R6: Every write frame is preceded, within the same grant, by a frame holding only the write-enable opcode 0x06.
- R7: A write frame begins with opcode 0x02 and then the byte address (twice the word offset), ADDR_BITS wide and MSB first. With 8 address bits and a word offset of 128 or more, bit 3 (0x08) of the opcode is set to carry address bit 8.
- R8: Each data word is sent as 16 bits MSB first after a byte swap, so bits [7:0] go out on the wire before bits [15:8].
- R9: A burst ends after the word whose following byte address is a multiple of PAGE_BYTES, or after the last word. Each further burst starts with a new access request.
- R10: On completion `done` is high for exactly one cycle, and `err` is low after a successful run. Afterwards `csn` is high and both `sk` and `access_req` are low.
- R11: `wr_ready` is high only while the block waits for a data word inside a selected write frame. Exactly the requested number of words is taken, in stream order.
- R12: After reset `csn` is high; `sk`, `di`, `access_req`, `wr_ready`, `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a run when the block is idle |
| start_offset | input | CW | First word offset |
| word_count | input | CW | Number of words to write |
| wr_data | input | 16 | Data word of the stream |
| wr_valid | input | 1 | Stream word available |
| wr_ready | output | 1 | Stream word accepted this cycle when valid |
| access_req | output | 1 | Bus ownership request |
| access_gnt | input | 1 | Bus ownership grant |
| csn | output | 1 | Chip select, active low |
| sk | output | 1 | Serial clock |
| di | output | 1 | Serial data to the part |
| sdo | input | 1 | Serial data from the part |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Failure flag, valid with `done`, held until next start |

## Verification
A corrupted state register or return pointer shows up within a single frame. The symptom is a frame whose opcode, length or write-enable ordering is wrong, or a `wr_ready` raised outside a selected frame. A wrong word or page counter is only visible at the first page boundary or at the end of the run: a burst that is too long or too short, a missing extra request, or a wrong address on the wire. A miscounted retry counter is seen as a wrong number of grant polls or status frames before `err`. The bench decodes every frame the part receives and compares each word's byte address, data and last-in-burst position against a queue built from the request.

// File: rtl/spi_eeprom_page_writer.sv
module spi_eeprom_page_writer #(
  parameter int OPW        = 8,
  parameter int ADDR_BITS  = 8,
  parameter int PAGE_BYTES = 32,
  parameter int WORD_SIZE  = 256,
  parameter int BIT_DLY    = 1,
  parameter int POLL_DLY   = 3,
  parameter int WCYC_DLY   = 12,
  parameter int GNT_TRIES  = 4,
  parameter int RDY_TRIES  = 4,
  localparam int CW = $clog2(WORD_SIZE + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] start_offset,
  input  logic [CW-1:0] word_count,
  input  logic [15:0]   wr_data,
  input  logic          wr_valid,
  output logic          wr_ready,
  output logic          access_req,
  input  logic          access_gnt,
  output logic          csn,
  output logic          sk,
  output logic          di,
  input  logic          sdo,
  output logic          done,
  output logic          err
);
  localparam int PW  = $clog2(PAGE_BYTES / 2);
  localparam int TW  = $clog2(WCYC_DLY + POLL_DLY + BIT_DLY + 2);
  localparam int MXT = (GNT_TRIES > RDY_TRIES) ? GNT_TRIES : RDY_TRIES;
  localparam int RW  = $clog2(MXT + 1);
  localparam logic [OPW-1:0] OP_WREN  = OPW'(8'h06);
  localparam logic [OPW-1:0] OP_WRITE = OPW'(8'h02);
  localparam logic [OPW-1:0] OP_RDSR  = OPW'(8'h05);
  localparam logic [OPW-1:0] OP_A8    = OPW'(8'h08);
  localparam bit A8_MODE = (ADDR_BITS == 8);

  typedef enum logic [3:0] {
    S_IDLE, S_REQ, S_PREP, S_RSOP, S_RSIN, S_RSCK, S_STBY, S_WREN,
    S_WOP, S_ADDR, S_DGET, S_DNXT, S_WCYC, S_REL, S_REL2, S_SH
  } st_t;

  st_t st, sh_ret, sb_ret;
  logic [1:0]    ph;
  logic [TW-1:0] tmr;
  logic [RW-1:0] tries;
  logic [CW-1:0] cur, left;
  logic [15:0]   sh;
  logic [4:0]    nbits;
  logic          rx, stat_lsb, err_pend;
  logic          bad;
  logic [ADDR_BITS-1:0] baddr;
  logic [OPW-1:0]       wop;

  assign bad = (start_offset >= CW'(WORD_SIZE)) || (word_count == '0) ||
               ({1'b0, word_count} > ({1'b0, CW'(WORD_SIZE)} - {1'b0, start_offset}));
  assign baddr    = ADDR_BITS'({cur, 1'b0});
  assign wop      = (A8_MODE && int'(cur) >= 128) ? (OP_WRITE | OP_A8) : OP_WRITE;
  assign wr_ready = (st == S_DGET) && (tmr == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; sh_ret <= S_IDLE; sb_ret <= S_IDLE;
      ph <= '0; tmr <= '0; tries <= '0; cur <= '0; left <= '0;
      sh <= '0; nbits <= '0; rx <= 1'b0; stat_lsb <= 1'b0; err_pend <= 1'b0;
      access_req <= 1'b0; csn <= 1'b1; sk <= 1'b0; di <= 1'b0;
      done <= 1'b0; err <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tmr != '0) tmr <= tmr - 1'b1;
      else begin
        case (st)
          S_IDLE: if (start) begin
            err <= 1'b0;
            if (bad) begin
              done <= 1'b1; err <= 1'b1;
            end else begin
              cur <= start_offset; left <= word_count; tries <= '0;
              err_pend <= 1'b0; access_req <= 1'b1; st <= S_REQ;
            end
          end
          S_REQ: begin
            access_req <= 1'b1;
            if (access_gnt) begin
              tries <= '0; st <= S_PREP;
            end else if (tries == RW'(GNT_TRIES - 1)) begin
              access_req <= 1'b0; done <= 1'b1; err <= 1'b1; st <= S_IDLE;
            end else begin
              tries <= tries + 1'b1; tmr <= TW'(POLL_DLY);
            end
          end
          S_PREP: begin
            csn <= 1'b0; sk <= 1'b0; tmr <= TW'(BIT_DLY); st <= S_RSOP;
          end
          S_RSOP: begin
            sh <= 16'(OP_RDSR) << (16 - OPW); nbits <= 5'(OPW); rx <= 1'b0;
            sh_ret <= S_RSIN; st <= S_SH;
          end
          S_RSIN: begin
            nbits <= 5'd8; rx <= 1'b1; sh_ret <= S_RSCK; st <= S_SH;
          end
          S_RSCK: begin
            if (!stat_lsb) begin
              sb_ret <= S_WREN; st <= S_STBY;
            end else if (tries == RW'(RDY_TRIES - 1)) begin
              err_pend <= 1'b1; st <= S_REL;
            end else begin
              tries <= tries + 1'b1; tmr <= TW'(POLL_DLY);
              sb_ret <= S_RSOP; st <= S_STBY;
            end
          end
          S_STBY: begin
            tmr <= TW'(BIT_DLY);
            if (ph == 2'd0) begin
              csn <= 1'b1; ph <= 2'd1;
            end else begin
              csn <= 1'b0; ph <= 2'd0; st <= sb_ret;
            end
          end
          S_WREN: begin
            sh <= 16'(OP_WREN) << (16 - OPW); nbits <= 5'(OPW); rx <= 1'b0;
            sh_ret <= S_STBY; sb_ret <= S_WOP; st <= S_SH;
          end
          S_WOP: begin
            sh <= 16'(wop) << (16 - OPW); nbits <= 5'(OPW); rx <= 1'b0;
            sh_ret <= S_ADDR; st <= S_SH;
          end
          S_ADDR: begin
            sh <= 16'(baddr) << (16 - ADDR_BITS); nbits <= 5'(ADDR_BITS); rx <= 1'b0;
            sh_ret <= S_DGET; st <= S_SH;
          end
          S_DGET: if (wr_valid) begin
            sh <= {wr_data[7:0], wr_data[15:8]}; nbits <= 5'd16; rx <= 1'b0;
            cur <= cur + 1'b1; left <= left - 1'b1;
            sh_ret <= S_DNXT; st <= S_SH;
          end
          S_DNXT: begin
            if (cur[PW-1:0] == '0) begin
              sb_ret <= S_WCYC; st <= S_STBY;
            end else if (left == '0) st <= S_WCYC;
            else st <= S_DGET;
          end
          S_WCYC: begin
            tmr <= TW'(WCYC_DLY); st <= S_REL;
          end
          S_REL: begin
            csn <= 1'b1; sk <= 1'b0; tmr <= TW'(BIT_DLY); st <= S_REL2;
          end
          S_REL2: begin
            access_req <= 1'b0;
            if (err_pend) begin
              done <= 1'b1; err <= 1'b1; st <= S_IDLE;
            end else if (left != '0) begin
              tries <= '0; tmr <= TW'(BIT_DLY); st <= S_REQ;
            end else begin
              done <= 1'b1; st <= S_IDLE;
            end
          end
          S_SH: begin
            tmr <= TW'(BIT_DLY);
            case (ph)
              2'd0: begin di <= rx ? 1'b0 : sh[15]; ph <= 2'd1; end
              2'd1: begin sk <= 1'b1; ph <= 2'd2; end
              default: begin
                sk <= 1'b0; ph <= 2'd0;
                if (rx) stat_lsb <= sdo;
                sh <= sh << 1; nbits <= nbits - 1'b1;
                if (nbits == 5'd1) begin
                  st <= sh_ret;
                  di <= 1'b0;
                end
              end
            endcase
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

module spi_eeprom_page_writer_chk (
  input logic clk,
  input logic rst_n,
  input logic csn,
  input logic sk,
  input logic access_req,
  input logic access_gnt,
  input logic wr_ready,
  input logic done,
  input logic err
);
  assert_idle_pins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !access_req |-> (csn && !sk));
  assert_sk_needs_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sk |-> !csn);
  assert_select_after_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(csn) |-> (access_req && access_gnt));
  assert_ready_in_frame_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (access_req && !csn));
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_err_with_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done);
endmodule

bind spi_eeprom_page_writer spi_eeprom_page_writer_chk u_chk (.*);

// File: tb/tb_spi_eeprom_page_writer.sv
module tb_spi_eeprom_page_writer;
  localparam int CW = 9;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [CW-1:0] start_offset = '0, word_count = '0;
  logic [15:0] wr_data = '0;
  logic wr_valid = 1'b0, access_gnt = 1'b0, sdo = 1'b0;
  wire wr_ready, access_req, csn, sk, di, done, err;

  int errors = 0, checks = 0;
  int frames = 0, rdsr_n = 0, wren_n = 0, req_rises = 0, busy_left = 0;
  bit fb[$];
  bit wel = 1'b0, gnt_en = 1'b1, take = 1'b0;
  logic [7:0] stat = 8'h00;
  int exp_a[$], exp_d[$], exp_l[$];
  logic [15:0] feed_q[$];

  always #10 clk = ~clk;

  spi_eeprom_page_writer dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_offset(start_offset),
    .word_count(word_count), .wr_data(wr_data), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .access_req(access_req), .access_gnt(access_gnt),
    .csn(csn), .sk(sk), .di(di), .sdo(sdo), .done(done), .err(err));

  task automatic check(bit ok, string rq, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, expv);
    end
  endtask

  function automatic logic [7:0] op_of();
    logic [7:0] v = 8'h00;
    for (int k = 0; k < 8; k++) v = {v[6:0], fb[k]};
    return v;
  endfunction

  task automatic analyze();
    int n, nw, ba, ea, ed, el;
    logic [7:0] op, addr;
    logic [15:0] v;
    n = fb.size();
    op = op_of();
    frames++;
    if (op == 8'h06 && n == 8) begin
      wel = 1'b1; wren_n++;
    end else if (op == 8'h05 && n == 16) begin
    end else if ((op == 8'h02 || op == 8'h0A) && n >= 32 && (n - 16) % 16 == 0) begin
      check(wel, "R6", "write enable before write frame", 0, 1);
      wel = 1'b0;
      addr = 8'h00;
      for (int k = 8; k < 16; k++) addr = {addr[6:0], fb[k]};
      nw = (n - 16) / 16;
      for (int i = 0; i < nw; i++) begin
        v = 16'h0;
        for (int k = 0; k < 16; k++) v = {v[14:0], fb[16 + 16 * i + k]};
        ba = (op[3] ? 256 : 0) + int'(addr) + 2 * i;
        if (exp_a.size() == 0) check(1'b0, "R11", "unexpected word", ba, -1);
        else begin
          ea = exp_a.pop_front(); ed = exp_d.pop_front(); el = exp_l.pop_front();
          check(ba == ea, "R7", "byte address", ba, ea);
          check(int'({v[7:0], v[15:8]}) == ed, "R8", "swapped data", int'({v[7:0], v[15:8]}), ed);
          check(int'(i == nw - 1) == el, "R9", "burst end", int'(i == nw - 1), el);
        end
      end
    end else check(1'b0, "R4", "malformed frame opcode", int'(op), n);
  endtask

  always @(negedge csn) if (rst_n) fb.delete();
  always @(posedge sk) if (rst_n) fb.push_back(di);
  always @(negedge sk) if (rst_n && !csn && fb.size() >= 8 && fb.size() < 16 && op_of() == 8'h05) begin
    if (fb.size() == 8) begin
      stat = (busy_left > 0) ? 8'h01 : 8'hF2;
      if (busy_left > 0) busy_left--;
      rdsr_n++;
    end
    sdo = stat[15 - fb.size()];
  end
  always @(posedge csn) if (rst_n && fb.size() > 0) analyze();
  always @(posedge access_req) if (rst_n) req_rises++;

  initial forever begin
    @(negedge clk);
    if (take) void'(feed_q.pop_front());
    wr_valid = feed_q.size() > 0;
    wr_data = wr_valid ? feed_q[0] : 16'h0;
    take = wr_valid && wr_ready;
    access_gnt = gnt_en && access_req;
  end

  task automatic run(int off, int cnt, bit push, bit exp_err, bit late_gnt, string rq);
    bit seen = 1'b0;
    int t = 0;
    logic [15:0] d;
    if (push) for (int i = 0; i < cnt; i++) begin
      d = 16'((off + i) * 16'h0137) ^ 16'hA55A;
      feed_q.push_back(d);
      exp_a.push_back(2 * (off + i));
      exp_d.push_back(int'(d));
      exp_l.push_back(int'(i == cnt - 1 || (off + i + 1) % 16 == 0));
    end
    if (late_gnt) gnt_en = 1'b0;
    @(negedge clk);
    start = 1'b1; start_offset = CW'(off); word_count = CW'(cnt);
    @(negedge clk);
    start = 1'b0;
    if (late_gnt) begin
      repeat (5) @(negedge clk);
      check(access_req && csn && !sk, "R2", "held off until grant", int'({access_req, csn, sk}), 3'b110);
      gnt_en = 1'b1;
    end
    while (!seen && t < 40000) begin
      if (done) seen = 1'b1;
      else begin @(negedge clk); t++; end
    end
    check(seen, "R10", {rq, " done seen"}, int'(seen), 1);
    check(err == exp_err, rq, "err flag", int'(err), int'(exp_err));
    @(negedge clk);
    check(!done, "R10", "done one cycle", int'(done), 0);
    check(csn && !sk && !access_req, "R10", "pins released", int'({csn, sk, access_req}), 3'b100);
    if (push) check(exp_a.size() == 0 && feed_q.size() == 0, "R11", "all words sent",
                    exp_a.size() + feed_q.size(), 0);
    exp_a.delete(); exp_d.delete(); exp_l.delete(); feed_q.delete();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int f0, q0, w0, s0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(csn && !sk && !di && !access_req && !wr_ready && !done && !err, "R12", "reset state",
          int'({csn, sk, di, access_req, wr_ready, done, err}), 7'b1000000);

    f0 = frames; q0 = req_rises;
    run(256, 1, 1'b0, 1'b1, 1'b0, "R1");
    run(250, 7, 1'b0, 1'b1, 1'b0, "R1");
    run(10, 0, 1'b0, 1'b1, 1'b0, "R1");
    check(frames == f0 && req_rises == q0, "R1", "no activity on reject", frames - f0 + req_rises - q0, 0);

    run(5, 1, 1'b1, 1'b0, 1'b0, "R10");
    run(250, 6, 1'b1, 1'b0, 1'b0, "R1");

    w0 = wren_n; q0 = req_rises;
    run(14, 5, 1'b1, 1'b0, 1'b0, "R9");
    check(wren_n - w0 == 2, "R6", "write enable per burst", wren_n - w0, 2);
    check(req_rises - q0 == 2, "R9", "request per burst", req_rises - q0, 2);

    run(200, 3, 1'b1, 1'b0, 1'b0, "R7");
    run(255, 1, 1'b1, 1'b0, 1'b0, "R7");

    q0 = req_rises;
    run(16, 16, 1'b1, 1'b0, 1'b0, "R9");
    check(req_rises - q0 == 1, "R9", "full page one burst", req_rises - q0, 1);

    busy_left = 2; s0 = rdsr_n;
    run(40, 2, 1'b1, 1'b0, 1'b0, "R4");
    check(rdsr_n - s0 == 3, "R4", "status polls", rdsr_n - s0, 3);

    busy_left = 50; s0 = rdsr_n; w0 = wren_n;
    run(40, 2, 1'b0, 1'b1, 1'b0, "R5");
    check(rdsr_n - s0 == 4, "R5", "status polls before error", rdsr_n - s0, 4);
    check(wren_n == w0, "R5", "no write after busy timeout", wren_n - w0, 0);
    busy_left = 0;

    gnt_en = 1'b0; f0 = frames;
    run(3, 2, 1'b0, 1'b1, 1'b0, "R3");
    check(frames == f0, "R3", "no frame without grant", frames - f0, 0);
    gnt_en = 1'b1;

    run(60, 3, 1'b1, 1'b0, 1'b1, "R2");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R10 watchdog expired: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule